// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only serial slave that lets a host load a small bank of 16-bit configuration words over three wires: an active-low select, a serial clock and a serial data line. While the select is low, the block shifts in one bit on every rising edge of the serial clock. A complete frame is 24 bits long and is sent in three parts: an 8-bit register address, then the lower data byte, then the upper data byte. Each part is sent least-significant bit first.

The frame is not acted on while it is being shifted. When the select returns high, the select level is passed through a synchroniser into the system clock domain. The rising edge is then detected there, and the word is written into the addressed register, but only if the frame held exactly 24 serial clock edges and the address falls inside the nine-register window 0xF0 to 0xF8. The register contents are presented as a flat parallel vector. A few decoded control fields are also brought out as separate ports: amplifier gain, filter select, output mode, monitor select and two code-format flags.

Top module: `sri_top`

## Requirements
- R1: While the hardware reset `rst_n` is low, and after it is released, every register reads 0x0000 and every field output is 0 until a valid frame is committed.
- R2: The bit taken on the k-th rising edge of `ser_clk` (k = 0..23) while `ser_sel_n` is low becomes frame bit k. Frame bits 7:0 are the address, bits 15:8 are data bits 7:0, and bits 23:16 are data bits 15:8. A committed write to address A puts the data in `cfg_flat[(A-0xF0)*16 +: 16]`.
- R3: Register contents do not change while `ser_sel_n` stays low, even after all 24 bits have arrived. They take the new value within 4 system clock cycles after `ser_sel_n` rises.
- R4: A frame with fewer than 24 serial clock edges before `ser_sel_n` rises is discarded, and no register changes.
- R5: A frame with more than 24 serial clock edges before `ser_sel_n` rises is discarded, and no register changes.
- R6: A complete frame whose address is below 0xF0 or above 0xF8 changes no register.
- R7: The field outputs decode as follows: `gain_code` = register 0xF0 bits 7:0; `filt_sel` = register 0xF1 bits 9:8; `out_mode` = register 0xF1 bits 4:2; `mon_sel` = register 0xF4 bits 2:0; `fmt_gray` = register 0xF4 bit 3; `fmt_diff` = register 0xF4 bit 4.
- R8: A committed frame changes only the one addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the commit and the register bank run on it |
| rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| ser_sel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, least-significant bit of each part first |
| gain_code | output | 8 | Amplifier gain code field |
| filt_sel | output | 2 | Filter select field |
| out_mode | output | 3 | Output mode field |
| mon_sel | output | 3 | Monitor select field |
| fmt_gray | output | 1 | Gray-code output format flag |
| fmt_diff | output | 1 | Differential-code output format flag |
| cfg_flat | output | 144 | All nine registers, register 0xF0 in bits 15:0 |

## Verification
The patterns are chosen to expose specific faults. Asymmetric data words such as 0xBEEF, 0x00A5 and 0x0314 show whether the bit order, the byte order or the address/data split is wrong, because a reversed or swapped frame lands on a different value or a different register. Frames of 23 and 26 edges test the exact-length rule from both sides. The addresses 0xEF, 0xF9 and 0x00 test both edges of the window and a far-out address. A frame held with the select still low for many cycles separates a commit on the select edge from a commit on the last bit. Writing distinct values to all nine registers, and comparing the whole bank after every frame, exposes any decode that reaches more than one register.

// File: rtl/sri_pkg.sv
package sri_pkg;

   // true when addr lies inside [base, base+count)
   function automatic bit in_window(input int unsigned addr,
                                    input int unsigned base,
                                    input int unsigned count);
      return (addr >= base) && (addr < base + count);
   endfunction

   // bits needed for a counter that saturates one above the frame length
   function automatic int unsigned cnt_bits(input int unsigned frame_len);
      return $clog2(frame_len + 2);
   endfunction

endpackage

// File: rtl/sri_shift.sv
module sri_shift #(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned CNT_W   = 5
) (
   input  logic               ser_clk,
   input  logic               ser_clr,
   input  logic               ser_sel_n,
   input  logic               ser_dat,
   output logic [FRAME_W-1:0] frame_q,
   output logic [CNT_W-1:0]   bit_cnt
);

   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

   // newest bit enters at the top, so the first bit ends at position 0
   always_ff @(posedge ser_clk or posedge ser_clr) begin
      if (ser_clr) begin
         frame_q <= '0;
      end else if (!ser_sel_n) begin
         frame_q <= {ser_dat, frame_q[FRAME_W-1:1]};
      end
   end

   // counts edges of the current frame, sticks at FRAME_W+1 for long frames
   always_ff @(posedge ser_clk or posedge ser_clr) begin
      if (ser_clr) begin
         bit_cnt <= '0;
      end else if (!ser_sel_n && (bit_cnt != CNT_SAT)) begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sri_commit.sv
module sri_commit #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned BASE        = 'hF0,
   parameter int unsigned NUM_REGS    = 9,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 5,
   localparam int unsigned FRAME_W    = ADDR_W + DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ser_sel_n,
   input  logic [FRAME_W-1:0]  frame_q,
   input  logic [CNT_W-1:0]    bit_cnt,
   output logic [NUM_REGS-1:0] wr_en,
   output logic [DATA_W-1:0]   wr_data,
   output logic                consume
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sel_last;
   logic                   sel_rise;
   logic                   frame_full;
   logic [ADDR_W-1:0]      frame_addr;

   // idle level of the select is high, so the chain resets to ones
   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= ser_sel_n;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ser_sel_n};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_last <= 1'b1;
         consume  <= 1'b0;
      end else begin
         sel_last <= sync_q[SYNC_STAGES-1];
         consume  <= sel_rise;
      end
   end

   assign sel_rise   = sync_q[SYNC_STAGES-1] & ~sel_last;
   assign frame_full = (bit_cnt == CNT_FULL);
   assign frame_addr = frame_q[ADDR_W-1:0];
   assign wr_data    = frame_q[FRAME_W-1:ADDR_W];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
         assign wr_en[i] = sel_rise && frame_full &&
                           (frame_addr == ADDR_W'(BASE + i));
      end
   endgenerate

endmodule

// File: rtl/sri_regbank.sv
module sri_regbank #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_REGS = 9,
   parameter int unsigned GAIN_IX  = 0,
   parameter int unsigned FILT_IX  = 1,
   parameter int unsigned MON_IX   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_REGS-1:0]        wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [NUM_REGS*DATA_W-1:0] cfg_flat,
   output logic [7:0]                 gain_code,
   output logic [1:0]                 filt_sel,
   output logic [2:0]                 out_mode,
   output logic [2:0]                 mon_sel,
   output logic                       fmt_gray,
   output logic                       fmt_diff
);

   logic [DATA_W-1:0] reg_q [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        reg_q[i] <= '0;
            else if (wr_en[i]) reg_q[i] <= wr_data;
         end
         assign cfg_flat[i*DATA_W +: DATA_W] = reg_q[i];
      end
   endgenerate

   // field taps; each is tied low when its register is absent from the bank
   generate
      if (GAIN_IX < NUM_REGS) begin : g_gain
         assign gain_code = reg_q[GAIN_IX][7:0];
      end else begin : g_gain_off
         assign gain_code = '0;
      end
      if (FILT_IX < NUM_REGS) begin : g_filt
         assign filt_sel = reg_q[FILT_IX][9:8];
         assign out_mode = reg_q[FILT_IX][4:2];
      end else begin : g_filt_off
         assign filt_sel = '0;
         assign out_mode = '0;
      end
      if (MON_IX < NUM_REGS) begin : g_mon
         assign mon_sel  = reg_q[MON_IX][2:0];
         assign fmt_gray = reg_q[MON_IX][3];
         assign fmt_diff = reg_q[MON_IX][4];
      end else begin : g_mon_off
         assign mon_sel  = '0;
         assign fmt_gray = 1'b0;
         assign fmt_diff = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/sri_top.sv
module sri_top #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned BASE        = 'hF0,
   parameter int unsigned NUM_REGS    = 9,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned FRAME_W    = ADDR_W + DATA_W,
   localparam int unsigned CNT_W      = sri_pkg::cnt_bits(FRAME_W),
   localparam int unsigned FLAT_W     = NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   output logic [7:0]        gain_code,
   output logic [1:0]        filt_sel,
   output logic [2:0]        out_mode,
   output logic [2:0]        mon_sel,
   output logic              fmt_gray,
   output logic              fmt_diff,
   output logic [FLAT_W-1:0] cfg_flat
);

   initial begin
      if (DATA_W < 10)
         $error("sri_top: DATA_W must hold the widest field (10 bits)");
      if (SYNC_STAGES < 2)
         $error("sri_top: SYNC_STAGES below 2 is not metastability safe");
      if (!sri_pkg::in_window(BASE + NUM_REGS - 1, 0, 2 ** ADDR_W))
         $error("sri_top: register window exceeds the address space");
   end

   logic [FRAME_W-1:0]  frame_q;
   logic [CNT_W-1:0]    bit_cnt;
   logic [NUM_REGS-1:0] wr_en;
   logic [DATA_W-1:0]   wr_data;
   logic                consume;
   logic                ser_clr;

   // serial state clears on reset and once the frame has been consumed
   assign ser_clr = ~rst_n | consume;

   sri_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shift_i (
      .ser_clk   (ser_clk),
      .ser_clr   (ser_clr),
      .ser_sel_n (ser_sel_n),
      .ser_dat   (ser_dat),
      .frame_q   (frame_q),
      .bit_cnt   (bit_cnt)
   );

   sri_commit #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .NUM_REGS(NUM_REGS),
      .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
   ) commit_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_sel_n (ser_sel_n),
      .frame_q   (frame_q),
      .bit_cnt   (bit_cnt),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .consume   (consume)
   );

   sri_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .cfg_flat  (cfg_flat),
      .gain_code (gain_code),
      .filt_sel  (filt_sel),
      .out_mode  (out_mode),
      .mon_sel   (mon_sel),
      .fmt_gray  (fmt_gray),
      .fmt_diff  (fmt_diff)
   );

endmodule

// File: rtl/sri_chk.sv
module sri_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned BASE     = 'hF0,
   parameter int unsigned NUM_REGS = 9,
   parameter int unsigned CNT_W    = 5
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ser_sel_n,
   input logic [NUM_REGS*DATA_W-1:0] cfg_flat,
   input logic [CNT_W-1:0]           bit_cnt,
   input logic [ADDR_W-1:0]          frame_addr
);

   localparam int unsigned FRAME_W = ADDR_W + DATA_W;

   logic [NUM_REGS*DATA_W-1:0] prev_flat;
   logic [NUM_REGS-1:0]        word_moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_flat <= '0;
      else        prev_flat <= cfg_flat;
   end

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_mv
         assign word_moved[i] =
            cfg_flat[i*DATA_W +: DATA_W] != prev_flat[i*DATA_W +: DATA_W];
      end
   endgenerate

   // R1: bank is clear when reset is released
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cfg_flat == '0));

   // R3: no update while the select has been low for two edges
   p_hold_select_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_sel_n && !$past(ser_sel_n)) |=> $stable(cfg_flat));

   // R4, R5: any update came from a frame of exactly the full length
   p_full_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_flat) |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

   // R6: any update came from an address inside the window
   p_window_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_flat) |->
         (int'($past(frame_addr)) >= int'(BASE) &&
          int'($past(frame_addr)) <  int'(BASE + NUM_REGS)));

   // R8: at most one register word moves per cycle
   p_single_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word_moved));

endmodule

bind sri_top sri_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE),
   .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ser_sel_n  (ser_sel_n),
   .cfg_flat   (cfg_flat),
   .bit_cnt    (bit_cnt),
   .frame_addr (frame_q[ADDR_W-1:0])
);

// File: tb/sri_tb.sv
`timescale 1ns/1ps
module sri_top_tb_top;

   localparam int NREG = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic ser_sel_n = 1'b1;
   logic ser_clk = 1'b0;
   logic ser_dat = 1'b0;
   logic [7:0]  gain_code;
   logic [1:0]  filt_sel;
   logic [2:0]  out_mode;
   logic [2:0]  mon_sel;
   logic        fmt_gray;
   logic        fmt_diff;
   logic [NREG*16-1:0] cfg_flat;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [15:0] exp_r [NREG];

   always #5 clk = ~clk;

   sri_top dut_i (
      .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .gain_code(gain_code), .filt_sel(filt_sel),
      .out_mode(out_mode), .mon_sel(mon_sel), .fmt_gray(fmt_gray),
      .fmt_diff(fmt_diff), .cfg_flat(cfg_flat)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // whole bank plus decoded fields against the bench model
   task automatic chk_bank(input string tag);
      for (int i = 0; i < NREG; i++)
         chk($sformatf("%s R8 reg%0d", tag, i), cfg_flat[i*16 +: 16], exp_r[i]);
      chk({tag, " R7 gain"}, 16'(gain_code), 16'(exp_r[0][7:0]));
      chk({tag, " R7 filt"}, 16'(filt_sel),  16'(exp_r[1][9:8]));
      chk({tag, " R7 mode"}, 16'(out_mode),  16'(exp_r[1][4:2]));
      chk({tag, " R7 mon"},  16'(mon_sel),   16'(exp_r[4][2:0]));
      chk({tag, " R7 gray"}, 16'(fmt_gray),  16'(exp_r[4][3]));
      chk({tag, " R7 diff"}, 16'(fmt_diff),  16'(exp_r[4][4]));
   endtask

   task automatic close_frame();
      ser_sel_n = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk);
   endtask

   // n serial edges; bits past 24 are sent as ones
   task automatic shift_bits(input logic [7:0] a, input logic [15:0] d, input int n);
      logic [23:0] w;
      w = {d, a};
      ser_sel_n = 1'b0;
      #15;
      for (int i = 0; i < n; i++) begin
         ser_dat = (i < 24) ? w[i] : 1'b1;
         #20 ser_clk = 1'b1;
         #20 ser_clk = 1'b0;
      end
      #15;
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [15:0] d);
      shift_bits(a, d, 24);
      close_frame();
      if (a >= 8'hF0 && a <= 8'hF8) exp_r[a - 8'hF0] = d;
   endtask

   task automatic t_reset();
      for (int i = 0; i < NREG; i++) exp_r[i] = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 in reset", cfg_flat[15:0], 16'h0000);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk_bank("R1 after reset");
   endtask

   task automatic t_fields();
      write_reg(8'hF0, 16'h00A5);
      chk_bank("R2 gain write");
      write_reg(8'hF1, 16'h0314);
      chk_bank("R2 filt/mode write");
      write_reg(8'hF4, 16'h0018);
      chk_bank("R7 format flags");
      write_reg(8'hF4, 16'h0006);
      chk_bank("R7 monitor");
   endtask

   task automatic t_hold_until_select();
      shift_bits(8'hF2, 16'hBEEF, 24);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R3 held while select low", cfg_flat[2*16 +: 16], exp_r[2]);
      close_frame();
      exp_r[2] = 16'hBEEF;
      chk("R3 committed on select rise", cfg_flat[2*16 +: 16], 16'hBEEF);
      chk_bank("R3 bank");
   endtask

   task automatic t_short_frame();
      shift_bits(8'hF3, 16'h1234, 23);
      close_frame();
      chk("R4 23-edge frame dropped", cfg_flat[3*16 +: 16], exp_r[3]);
      shift_bits(8'hF0, 16'h00FF, 8);
      close_frame();
      chk_bank("R4 8-edge frame dropped");
   endtask

   task automatic t_long_frame();
      shift_bits(8'hF5, 16'h5A5A, 26);
      close_frame();
      chk("R5 26-edge frame dropped", cfg_flat[5*16 +: 16], exp_r[5]);
      chk_bank("R5 bank");
   endtask

   task automatic t_window();
      write_reg(8'hF9, 16'hFFFF);
      chk_bank("R6 addr F9");
      write_reg(8'hEF, 16'hFFFF);
      chk_bank("R6 addr EF");
      write_reg(8'h00, 16'hFFFF);
      chk_bank("R6 addr 00");
   endtask

   task automatic t_isolation();
      for (int i = 0; i < NREG; i++) begin
         write_reg(8'(8'hF0 + i), 16'(16'h1111 * (i + 1)) ^ 16'h8001);
         chk_bank($sformatf("R8 step %0d", i));
      end
      write_reg(8'hF8, 16'h0000);
      chk_bank("R2 top register cleared");
   endtask

   initial begin
      t_reset();
      t_fields();
      t_hold_until_select();
      t_short_frame();
      t_long_frame();
      t_window();
      t_isolation();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule